// File: doc/BRIEF.md
# Stereo Transmit Sample Queue

This block sits between a register-write port and a serial audio transmitter. Software writes the left and the right sample of a stereo pair as two separate writes, chosen by a select bit. The left word waits in a holding register. When the right word is written, the two are stored together as one queue entry. The transmitter takes whole pairs from the head of the queue. The head pair is always shown on the output, and a pop request removes it.

The queue holds eight pairs by default. It reports full, empty and a fill level on a status word. It raises one interrupt line. That line combines two sources: a fill-level condition, where a mode bit chooses between half empty and fully empty, and a sticky underflow flag. A separate enable gates the interrupt line.

A channel enable controls draining. When the enable falls, the queue and the pairing state are flushed. While the channel is off, software may still load the queue, and nothing is drained. Turning the channel back on resumes draining from a clean pairing state.

Top module: `audio_tx_fifo`

## Requirements
- R1: Each right-word write (`host_sel_right`=1) stores one entry made of the held left word and the written right word. Entries leave in write order. `tx_left`/`tx_right` show the oldest entry, and `tx_avail` is 1 whenever the queue holds an entry.
- R2: The queue holds DEPTH (8) pairs. Status bit 12 reads 1 only while DEPTH pairs are stored. Status bit 2 reads 1 while the queue is empty. After reset the status word is 0x0004.
- R3: While the queue is full, both left and right writes are dropped and leave the stored contents unchanged.
- R4: A right write stores a zero left word when no left word has been written since the last stored pair. When two left writes come in a row, the later one is used.
- R5: Status bit 1 is the level condition, and it is only active while `chan_en`=1. With `lvl_sel`=0 it reads 1 when at most DEPTH/2 pairs are stored. With `lvl_sel`=1 it reads 1 only when the queue is empty.
- R6: `irq` equals `irq_en` AND (status bit 1 OR status bit 0). With `irq_en`=0, `irq` is 0.
- R7: A pop while the queue is empty and `chan_en`=1 sets status bit 0 (underflow). The bit stays set until a cycle with `irq_ack`=1 and no new underflow. If an underflow and an acknowledge happen in the same cycle, the bit stays set.
- R8: A 1-to-0 transition of `chan_en` empties the queue and discards a held left word. The underflow flag is not changed by this.
- R9: While `chan_en`=0, pops neither remove entries nor set underflow, and writes are still accepted. After re-enable, those entries drain in order, and the queue can again be filled to full.
- R10: A stored write and a pop in the same cycle on a non-empty queue leave the entry count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel enable; a falling edge flushes the queue |
| host_wr | input | 1 | Write strobe |
| host_sel_right | input | 1 | 0 = write a left word, 1 = write a right word and store the pair |
| host_wdata | input | 32 | Sample word |
| lvl_sel | input | 1 | Level mode: 0 = half empty, 1 = empty |
| irq_en | input | 1 | Interrupt enable |
| irq_ack | input | 1 | Clears the underflow flag |
| tx_pop | input | 1 | Transmitter takes the head pair |
| tx_left | output | 32 | Left word of the head pair (0 when empty) |
| tx_right | output | 32 | Right word of the head pair (0 when empty) |
| tx_avail | output | 1 | Queue is not empty |
| status | output | 16 | bit0 underflow, bit1 level, bit2 empty, bit12 full, others 0 |
| irq | output | 1 | Transmit interrupt |

## Verification
The pairing logic is tested with three write patterns: alternating left and right writes, a right write with no left before it, and two left writes in a row. These show whether the held word is cleared after each store and whether a later left write overwrites an earlier one. The queue is filled to exactly seven and then eight pairs, and one more pair is written while full. This shows whether the full bit switches on the right pair and whether the extra write is truly dropped. The fill-level mode is tested at five and four stored pairs and at zero, which separates the half-empty threshold from the empty threshold. Flush, writes made while disabled, and a simultaneous write and pop each change the order in which entries drain, so any mistake in them shows up in the popped sequence.

// File: rtl/audio_txq_pkg.sv
package audio_txq_pkg;

    localparam int SAMPLE_W       = 32;
    localparam int STAT_W         = 16;
    localparam int STAT_UFL_BIT   = 0;
    localparam int STAT_LVL_BIT   = 1;
    localparam int STAT_EMPTY_BIT = 2;
    localparam int STAT_FULL_BIT  = 12;

    typedef logic [SAMPLE_W-1:0] sample_t;

    typedef struct packed {
        sample_t left;
        sample_t right;
    } pair_t;

    typedef enum logic {
        LVL_HALF  = 1'b0,
        LVL_EMPTY = 1'b1
    } lvl_mode_e;

    // Level condition for a given fill and mode
    function automatic logic level_reached(input lvl_mode_e mode,
                                           input int unsigned fill,
                                           input int unsigned depth);
        if (mode == LVL_EMPTY)
            return fill == 0;
        return fill <= depth / 2;
    endfunction

endpackage

// File: rtl/txq_pairer.sv
module txq_pairer
    import audio_txq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    flush,
    input  logic    wr,
    input  logic    wr_right,
    input  sample_t wdata,
    input  logic    full,
    output logic    push,
    output pair_t   push_pair
);

    sample_t left_q;
    logic    accept;

    assign accept = wr & ~full & ~flush;
    assign push   = accept & wr_right;

    always_comb begin
        push_pair.left  = left_q;
        push_pair.right = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            left_q <= '0;
        end else if (accept && !wr_right) begin
            left_q <= wdata;
        end else if (push) begin
            left_q <= '0;
        end
    end

    AST_PAIR_CLEARS: assert property (@(posedge clk) disable iff (rst)
        push |=> (left_q == '0)); // R4

endmodule

// File: rtl/txq_store.sv
module txq_store
    import audio_txq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  pair_t            push_pair,
    input  logic             pop,
    output pair_t            head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    pair_t            mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             do_push;
    logic             do_pop;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_pop  = pop & ~empty;
    assign do_push = push & ~full;
    assign head    = empty ? '0 : mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push && !flush && !rst)
            mem[wr_ptr] <= push_pair;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push)
                wr_ptr <= ptr_next(wr_ptr);
            if (do_pop)
                rd_ptr <= ptr_next(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH)); // R2
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        flush |=> (count == '0)); // R8
    AST_PUSH_POP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (push && pop && !empty && !full && !flush) |=> $stable(count)); // R10

endmodule

// File: rtl/txq_irq.sv
module txq_irq
    import audio_txq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             chan_en,
    input  logic             lvl_sel,
    input  logic             irq_en,
    input  logic             irq_ack,
    input  logic             pop_req,
    input  logic             empty,
    input  logic [CNT_W-1:0] count,
    output logic             ufl,
    output logic             level,
    output logic             irq
);

    logic ufl_set;

    assign ufl_set = pop_req & chan_en & empty;
    assign level   = chan_en &
                     level_reached(lvl_mode_e'(lvl_sel), 32'(count), DEPTH);
    assign irq     = irq_en & (level | ufl);

    always_ff @(posedge clk) begin
        if (rst)
            ufl <= 1'b0;
        else if (ufl_set)
            ufl <= 1'b1;
        else if (irq_ack)
            ufl <= 1'b0;
    end

    AST_UFL_SET: assert property (@(posedge clk) disable iff (rst)
        ufl_set |=> ufl); // R7
    AST_UFL_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ufl && !irq_ack) |=> ufl); // R7

endmodule

// File: rtl/audio_tx_fifo.sv
module audio_tx_fifo
    import audio_txq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
)(
    input  logic                clk,
    input  logic                rst,
    input  logic                chan_en,
    input  logic                host_wr,
    input  logic                host_sel_right,
    input  logic [SAMPLE_W-1:0] host_wdata,
    input  logic                lvl_sel,
    input  logic                irq_en,
    input  logic                irq_ack,
    input  logic                tx_pop,
    output logic [SAMPLE_W-1:0] tx_left,
    output logic [SAMPLE_W-1:0] tx_right,
    output logic                tx_avail,
    output logic [STAT_W-1:0]   status,
    output logic                irq
);

    logic             en_q;
    logic             flush;
    logic             push;
    pair_t            push_pair;
    pair_t            head;
    logic [CNT_W-1:0] count;
    logic             full;
    logic             empty;
    logic             ufl;
    logic             level;

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= 1'b0;
        else
            en_q <= chan_en;
    end

    assign flush = en_q & ~chan_en;

    txq_pairer u_pairer (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .wr        (host_wr),
        .wr_right  (host_sel_right),
        .wdata     (host_wdata),
        .full      (full),
        .push      (push),
        .push_pair (push_pair)
    );

    txq_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .push      (push),
        .push_pair (push_pair),
        .pop       (tx_pop & chan_en),
        .head      (head),
        .count     (count),
        .full      (full),
        .empty     (empty)
    );

    txq_irq #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .chan_en (chan_en),
        .lvl_sel (lvl_sel),
        .irq_en  (irq_en),
        .irq_ack (irq_ack),
        .pop_req (tx_pop),
        .empty   (empty),
        .count   (count),
        .ufl     (ufl),
        .level   (level),
        .irq     (irq)
    );

    assign tx_left  = head.left;
    assign tx_right = head.right;
    assign tx_avail = ~empty;

    always_comb begin
        status                 = '0;
        status[STAT_UFL_BIT]   = ufl;
        status[STAT_LVL_BIT]   = level;
        status[STAT_EMPTY_BIT] = empty;
        status[STAT_FULL_BIT]  = full;
    end

    AST_IDLE_NO_UFL: assert property (@(posedge clk) disable iff (rst)
        (tx_pop && !chan_en && !status[STAT_UFL_BIT]) |=> !status[STAT_UFL_BIT]); // R9
    AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (tx_pop && !chan_en && en_q == 1'b0 && !host_wr) |=> $stable(tx_avail)); // R9

endmodule

// File: tb/tb_audio_tx_fifo.sv
`timescale 1ns/1ps
module tb_audio_tx_fifo;

    logic        clk = 1'b0;
    logic        rst;
    logic        chan_en;
    logic        host_wr;
    logic        host_sel_right;
    logic [31:0] host_wdata;
    logic        lvl_sel;
    logic        irq_en;
    logic        irq_ack;
    logic        tx_pop;
    logic [31:0] tx_left;
    logic [31:0] tx_right;
    logic        tx_avail;
    logic [15:0] status;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    audio_tx_fifo dut (
        .clk(clk), .rst(rst), .chan_en(chan_en), .host_wr(host_wr),
        .host_sel_right(host_sel_right), .host_wdata(host_wdata),
        .lvl_sel(lvl_sel), .irq_en(irq_en), .irq_ack(irq_ack),
        .tx_pop(tx_pop), .tx_left(tx_left), .tx_right(tx_right),
        .tx_avail(tx_avail), .status(status), .irq(irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_word(input logic right, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_sel_right = right; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic wr_pair(input logic [31:0] l, input logic [31:0] r);
        wr_word(1'b0, l);
        wr_word(1'b1, r);
    endtask

    task automatic pop_one();
        @(negedge clk);
        tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    function automatic logic [31:0] lv(input int i); return 32'h1000_0000 + i; endfunction
    function automatic logic [31:0] rv(input int i); return 32'h2000_0000 + i; endfunction

    task automatic t_reset();
        chk("R2 reset status", status, 16'h0004);
        chk("R2 reset avail", tx_avail, 0);
        chk("R6 reset irq", irq, 0);
    endtask

    task automatic t_order();
        for (int i = 0; i < 3; i++) wr_pair(lv(i), rv(i));
        chk("R1 avail", tx_avail, 1);
        for (int i = 0; i < 3; i++) begin
            chk("R1 head left", tx_left, lv(i));
            chk("R1 head right", tx_right, rv(i));
            pop_one();
        end
        chk("R2 empty after drain", status[2], 1);
    endtask

    task automatic t_full();
        for (int i = 0; i < 7; i++) wr_pair(lv(i), rv(i));
        chk("R2 not full at 7", status[12], 0);
        wr_pair(lv(7), rv(7));
        chk("R2 full at 8", status[12], 1);
        wr_pair(32'hDEAD, 32'hBEEF);
        chk("R3 still full", status[12], 1);
        chk("R3 head kept", tx_left, lv(0));
        pop_one();
        chk("R2 full clears", status[12], 0);
        for (int i = 1; i < 8; i++) begin
            chk("R3 drain left", tx_left, lv(i));
            chk("R3 drain right", tx_right, rv(i));
            pop_one();
        end
        chk("R3 dropped pair absent", status[2], 1);
    endtask

    task automatic t_orphan();
        wr_word(1'b1, 32'h55);
        chk("R4 orphan left zero", tx_left, 0);
        chk("R4 orphan right", tx_right, 32'h55);
        pop_one();
        wr_word(1'b0, 32'hA);
        wr_word(1'b0, 32'hB);
        wr_word(1'b1, 32'hC);
        chk("R4 later left wins", tx_left, 32'hB);
        chk("R4 right", tx_right, 32'hC);
        pop_one();
    endtask

    task automatic t_level();
        @(negedge clk); irq_en = 1'b1; lvl_sel = 1'b0; #1;
        chk("R5 half mode empty irq", irq, 1);
        for (int i = 0; i < 5; i++) wr_pair(lv(i), rv(i));
        chk("R5 level off at 5", status[1], 0);
        chk("R6 irq off at 5", irq, 0);
        pop_one();
        chk("R5 level on at 4", status[1], 1);
        chk("R6 irq on at 4", irq, 1);
        lvl_sel = 1'b1; #1;
        chk("R5 empty mode at 4", irq, 0);
        lvl_sel = 1'b0; irq_en = 1'b0; #1;
        chk("R6 masked", irq, 0);
        chk("R5 level still on", status[1], 1);
        for (int i = 0; i < 4; i++) pop_one();
        lvl_sel = 1'b1; irq_en = 1'b1; #1;
        chk("R5 empty mode at 0", irq, 1);
        irq_en = 1'b0; lvl_sel = 1'b0;
    endtask

    task automatic t_underflow();
        pop_one();
        chk("R7 underflow set", status[0], 1);
        chk("R6 irq masked", irq, 0);
        for (int i = 0; i < 8; i++) wr_pair(lv(i), rv(i));
        chk("R7 sticky", status[0], 1);
        irq_en = 1'b1; #1;
        chk("R6 irq from underflow", irq, 1);
        ack();
        chk("R7 cleared", status[0], 0);
        chk("R6 irq after ack", irq, 0);
        for (int i = 0; i < 8; i++) pop_one();
        @(negedge clk); tx_pop = 1'b1; irq_ack = 1'b1;
        @(negedge clk); tx_pop = 1'b0; irq_ack = 1'b0;
        chk("R7 set wins over ack", status[0], 1);
        ack();
        chk("R7 cleared again", status[0], 0);
        irq_en = 1'b0;
    endtask

    task automatic t_flush();
        for (int i = 0; i < 3; i++) wr_pair(lv(i), rv(i));
        wr_word(1'b0, 32'h77);
        @(negedge clk); chan_en = 1'b0;
        @(negedge clk);
        chk("R8 flushed empty", status[2], 1);
        chk("R8 avail off", tx_avail, 0);
        pop_one();
        chk("R9 no underflow disabled", status[0], 0);
        wr_pair(lv(20), rv(20));
        wr_pair(lv(21), rv(21));
        pop_one();
        chk("R9 pop ignored", tx_left, lv(20));
        @(negedge clk); chan_en = 1'b1;
        wr_word(1'b1, 32'h99);
        chk("R9 head after enable", tx_right, rv(20));
        pop_one();
        chk("R9 second", tx_left, lv(21));
        pop_one();
        chk("R8 held left discarded", tx_left, 0);
        chk("R8 right", tx_right, 32'h99);
        pop_one();
        @(negedge clk); chan_en = 1'b0;
        @(negedge clk); chan_en = 1'b1;
        for (int i = 0; i < 8; i++) wr_pair(lv(i), rv(i));
        chk("R9 refill full", status[12], 1);
        for (int i = 0; i < 8; i++) pop_one();
        chk("R9 drained", status[2], 1);
    endtask

    task automatic t_simul();
        wr_pair(32'hA1, 32'hA2);
        wr_pair(32'hB1, 32'hB2);
        @(negedge clk);
        tx_pop = 1'b1; host_wr = 1'b1; host_sel_right = 1'b1; host_wdata = 32'hC2;
        @(negedge clk);
        tx_pop = 1'b0; host_wr = 1'b0;
        chk("R10 head B", tx_left, 32'hB1);
        pop_one();
        chk("R10 head C", tx_right, 32'hC2);
        chk("R10 not empty", tx_avail, 1);
        pop_one();
        chk("R10 empty after two", tx_avail, 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; chan_en = 1'b0; host_wr = 1'b0; host_sel_right = 1'b0;
        host_wdata = '0; lvl_sel = 1'b0; irq_en = 1'b0; irq_ack = 1'b0; tx_pop = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        chan_en = 1'b1;
        t_order();
        t_full();
        t_orphan();
        t_level();
        t_underflow();
        t_flush();
        t_simul();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule